// File: doc/BRIEF.md
# I2C-Controlled Two-Channel Bus Selector

This block is a small I2C target that owns a single control byte. The byte steers a 1-of-2 selector for two downstream bus pairs. A host addresses the block, writes a byte that names the channel to connect (or none), and the new choice takes effect only when the host ends the transfer with a STOP. The block therefore never joins a downstream pair while a transaction is still running.

The block also merges two active-low interrupt lines, one from each downstream pair, into a single active-low interrupt toward the host. A read of the control byte returns the stored selection bits together with the live level of both interrupt lines. The host can then find the pair that raised the request and connect to it.

SCL and SDA arrive as inputs that are already synchronized to `clk`. The block drives SDA through an open-drain pull-low enable.

Top module: `chanSelI2c`

## Requirements
- R1: The 7-bit target address is a 4-bit parameter (default 1110) followed by the three `addrStrap` pins. The bit after the address is the direction bit, where 1 means read and 0 means write. A matching address byte is acknowledged.
- R2: After an acknowledged write address, every byte received is stored as the control byte. When several bytes arrive in one transfer, only the last one is kept.
- R3: A newly written selection leaves `chanEnable` unchanged until a STOP (SDA rising while SCL is high) is seen. At that STOP, `chanEnable` takes the new value.
- R4: Control bit 2 enables a connection and bit 0 picks the pair. Value 1x0 gives `chanEnable`=01, value 1x1 gives 10, and any value with bit 2 clear gives 00. At most one enable is ever high.
- R5: A read returns the byte {0, 0, irq1, irq0, stored bits 3..0}. Bits 7:6 read 0 whatever was written. Bit 4 reads 1 while `irqInN[0]` is low, and bit 5 reads 1 while `irqInN[1]` is low. The values written to bits 5:4 have no effect on what is read there.
- R6: `irqOutN` is the AND of the two `irqInN` lines, so it is low while either input is low.
- R7: The block pulls SDA low for the acknowledge clock after its address and after each written byte. On a read it shifts the byte out MSB first. A master not-acknowledge ends the read and leaves SDA released.
- R8: Reset clears the control byte, the selection and the bus state machine. After reset, no channel is enabled and SDA is released.
- R9: Interrupt status is reported whether or not a channel is selected, and both interrupt bits can read 1 together.
- R10: An address that does not match gets no acknowledge. The rest of that transfer is ignored until the next START or STOP, so the bytes that follow leave the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronized SCL level |
| sdaIn | input | 1 | Synchronized SDA level (wired bus value) |
| addrStrap | input | 3 | Low three address bits from strap pins |
| irqInN | input | 2 | Active-low interrupt from each downstream pair |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| chanEnable | output | 2 | One-hot-or-zero connect enable per downstream pair |
| irqOutN | output | 1 | Active-low combined interrupt |

## Verification
The selection path is driven with the codes 100, 101 and 001, and each is checked both before and after the STOP. This separates a pending selection from an applied one, and separates the enable bit from the channel bit. A multi-byte write whose last byte disables the selector shows whether the block keeps the last byte rather than the first. Reads are made with no interrupt, with one interrupt and with both interrupts, using control values that have bits 7:4 set. These show whether the status bits come from the live pins and are kept apart from the written bits. A mismatched strap address followed by data, and a reset in the middle of operation, show whether either one leaves stale state behind.

// File: rtl/selPkg.sv
package selPkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic rxShift;    // sample SDA into receive shifter
    logic storeCtrl;  // copy received byte into control byte
    logic loadTx;     // load read-back byte into transmit shifter
    logic shiftTx;    // advance transmit shifter
    logic applySel;   // commit pending selection (STOP seen)
  } selStrobe_t;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_ADDR_ACK,
    BUS_WR,
    BUS_WR_ACK,
    BUS_RD,
    BUS_RD_ACK,
    BUS_SKIP
  } busState_t;
endpackage

// File: rtl/selCtrl.sv
module selCtrl
  import selPkg::*;
#(
  parameter int ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b1110,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic [BYTE_W-1:0]  rxByte,
  output selStrobe_t         stb,
  output logic               ackLow,
  output logic               txActive
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  logic sclQ, sdaQ;
  busState_t state, nState;
  logic [CNT_W-1:0] bitCnt, nCnt;

  logic sclRise, sclFall, startCond, stopCond, addrHit;

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startCond = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopCond  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign addrHit   = (rxByte[BYTE_W-1:1] == {ADDR_HI, addrStrap});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      state  <= BUS_IDLE;
      bitCnt <= '0;
    end else begin
      sclQ   <= sclIn;
      sdaQ   <= sdaIn;
      state  <= nState;
      bitCnt <= nCnt;
    end
  end

  always_comb begin
    stb    = '0;
    nState = state;
    nCnt   = bitCnt;
    if (stopCond) begin
      nState       = BUS_IDLE;
      nCnt         = '0;
      stb.applySel = 1'b1;
    end else if (startCond) begin
      nState = BUS_ADDR;
      nCnt   = '0;
    end else begin
      unique case (state)
        BUS_ADDR: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            nCnt        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            nState = addrHit ? BUS_ADDR_ACK : BUS_SKIP;
          end
        end
        BUS_ADDR_ACK: begin
          if (sclFall) begin
            nCnt = '0;
            if (rxByte[0]) begin
              nState     = BUS_RD;
              stb.loadTx = 1'b1;
            end else begin
              nState = BUS_WR;
            end
          end
        end
        BUS_WR: begin
          if (sclRise) begin
            stb.rxShift = 1'b1;
            nCnt        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_CNT) begin
            nState        = BUS_WR_ACK;
            stb.storeCtrl = 1'b1;
          end
        end
        BUS_WR_ACK: begin
          if (sclFall) begin
            nState = BUS_WR;
            nCnt   = '0;
          end
        end
        BUS_RD: begin
          if (sclFall) begin
            if (bitCnt == LAST_TX) begin
              nState = BUS_RD_ACK;
            end else begin
              stb.shiftTx = 1'b1;
              nCnt        = bitCnt + 1'b1;
            end
          end
        end
        BUS_RD_ACK: begin
          if (sclRise && sdaIn) begin
            nState = BUS_SKIP;
          end else if (sclFall) begin
            nState     = BUS_RD;
            nCnt       = '0;
            stb.loadTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ackLow   = (state == BUS_ADDR_ACK) || (state == BUS_WR_ACK);
  assign txActive = (state == BUS_RD);
endmodule

// File: rtl/selData.sv
module selData
  import selPkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  selStrobe_t        stb,
  input  logic [NUM_CH-1:0] irqInN,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [NUM_CH-1:0] chanEnable
);
  localparam int CH_BITS  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ENA_BIT  = 2;
  localparam int KEEP_W   = 4;
  localparam int IRQ_BASE = 4;

  logic [BYTE_W-1:0]  rxReg, txReg, readByte;
  logic [KEEP_W-1:0]  ctrlReg;
  logic               actEn;
  logic [CH_BITS-1:0] actCh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '0;
      ctrlReg <= '0;
      actEn   <= 1'b0;
      actCh   <= '0;
    end else begin
      if (stb.rxShift)   rxReg   <= {rxReg[BYTE_W-2:0], sdaIn};
      if (stb.storeCtrl) ctrlReg <= rxReg[KEEP_W-1:0];
      if (stb.loadTx)    txReg   <= readByte;
      else if (stb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b0};
      if (stb.applySel) begin
        actEn <= ctrlReg[ENA_BIT];
        actCh <= ctrlReg[CH_BITS-1:0];
      end
    end
  end

  always_comb begin
    readByte = '0;
    readByte[KEEP_W-1:0] = ctrlReg;
    readByte[IRQ_BASE +: NUM_CH] = ~irqInN;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    assign chanEnable[i] = actEn && (actCh == CH_BITS'(i));
  end

  assign rxByte = rxReg;
  assign txMsb  = txReg[BYTE_W-1];
endmodule

// File: rtl/chanSelI2c.sv
module chanSelI2c
  import selPkg::*;
#(
  parameter int ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b1110,
  parameter int STRAP_W = 3,
  parameter int NUM_CH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic [NUM_CH-1:0]  irqInN,
  output logic               sdaPullLow,
  output logic [NUM_CH-1:0]  chanEnable,
  output logic               irqOutN
);
  selStrobe_t        stb;
  logic [BYTE_W-1:0] rxByte;
  logic              ackLow, txActive, txMsb;

  selCtrl #(.ADDR_HI_W(ADDR_HI_W), .ADDR_HI(ADDR_HI), .STRAP_W(STRAP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .rxByte(rxByte), .stb(stb),
    .ackLow(ackLow), .txActive(txActive)
  );

  selData #(.NUM_CH(NUM_CH)) data_i (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .stb(stb), .irqInN(irqInN),
    .rxByte(rxByte), .txMsb(txMsb), .chanEnable(chanEnable)
  );

  assign sdaPullLow = ackLow | (txActive & ~txMsb);
  assign irqOutN    = &irqInN;
endmodule

// File: rtl/chanSelI2cChk.sv
module chanSelI2cChk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sdaPullLow,
  input logic [NUM_CH-1:0] chanEnable
);
  // R4
  one_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanEnable));

  // R3
  stop_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanEnable) |-> ($past(sclIn) && $past(sclIn, 2) && $past(sdaIn) && !$past(sdaIn, 2)));

  // R7
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaPullLow));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (chanEnable == '0 && !sdaPullLow));
endmodule

bind chanSelI2c chanSelI2cChk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaPullLow(sdaPullLow), .chanEnable(chanEnable)
);

// File: tb/chanSelI2c_tb_top.sv
module chanSelI2c_tb_top;
  localparam int Q = 4;
  localparam logic [6:0] MY_ADDR = 7'b1110101;
  localparam logic [6:0] BAD_ADDR = 7'b1110100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] addrStrap = 3'b101;
  logic [1:0] irqInN = 2'b11;
  logic sdaPullLow, irqOutN;
  logic [1:0] chanEnable;
  logic busSda;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign busSda = sdaM & ~sdaPullLow;

  chanSelI2c dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(busSda),
    .addrStrap(addrStrap), .irqInN(irqInN), .sdaPullLow(sdaPullLow),
    .chanEnable(chanEnable), .irqOutN(irqOutN)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sclM = 1'b0;
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q / 2);
    b = busSda; waitClk(Q / 2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(a);
    ack = ~a;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(~giveAck);
  endtask

  task automatic writeCtrl(input logic [7:0] v, input logic [1:0] expBefore);
    logic ack;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    chk("R1 address ack", {7'd0, ack}, 8'd1);
    sendByte(v, ack);
    chk("R7 data ack", {7'd0, ack}, 8'd1);
    waitClk(Q);
    chk("R3 selection pending before STOP", {6'd0, chanEnable}, {6'd0, expBefore});
    busStop();
  endtask

  task automatic readCtrl(output logic [7:0] v);
    logic ack;
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    chk("R1 read address ack", {7'd0, ack}, 8'd1);
    recvByte(1'b0, v);
    waitClk(Q);
    chk("R7 SDA released after NACK", {7'd0, sdaPullLow}, 8'd0);
    busStop();
  endtask

  task automatic testReset();
    chk("R8 no channel after reset", {6'd0, chanEnable}, 8'd0);
    chk("R8 SDA released after reset", {7'd0, sdaPullLow}, 8'd0);
    chk("R6 irq idle", {7'd0, irqOutN}, 8'd1);
  endtask

  task automatic testSelect();
    writeCtrl(8'h04, 2'b00);
    chk("R4 code 100 selects pair 0", {6'd0, chanEnable}, 8'h01);
    writeCtrl(8'h05, 2'b01);
    chk("R4 code 101 selects pair 1", {6'd0, chanEnable}, 8'h02);
  endtask

  task automatic testMultiByte();
    logic ack;
    busStart();
    sendByte({MY_ADDR, 1'b0}, ack);
    sendByte(8'h04, ack);
    sendByte(8'h01, ack);
    chk("R7 ack on second byte", {7'd0, ack}, 8'd1);
    busStop();
    waitClk(Q);
    chk("R2 last byte kept, R4 bit2 clear gives none", {6'd0, chanEnable}, 8'h00);
  endtask

  task automatic testReadBack();
    logic [7:0] v;
    logic ack;
    irqInN = 2'b11;
    writeCtrl(8'hF2, 2'b00);
    readCtrl(v);
    chk("R5 top bits zero, irq bits live", v, 8'h02);
    irqInN = 2'b10;
    waitClk(Q);
    chk("R6 one irq low", {7'd0, irqOutN}, 8'd0);
    readCtrl(v);
    chk("R9 irq0 seen with no channel selected", v, 8'h12);
    irqInN = 2'b00;
    busStart();
    sendByte({MY_ADDR, 1'b1}, ack);
    recvByte(1'b1, v);
    chk("R9 both irq bits", v, 8'h32);
    recvByte(1'b0, v);
    chk("R7 second read byte repeats", v, 8'h32);
    waitClk(Q);
    chk("R7 released after NACK", {7'd0, sdaPullLow}, 8'd0);
    busStop();
    irqInN = 2'b01;
    waitClk(Q);
    readCtrl(v);
    chk("R5 irq1 alone", v, 8'h22);
    irqInN = 2'b11;
    waitClk(Q);
    chk("R6 irq released", {7'd0, irqOutN}, 8'd1);
  endtask

  task automatic testMismatch();
    logic ack;
    logic [7:0] v;
    writeCtrl(8'h05, 2'b00);
    busStart();
    sendByte({BAD_ADDR, 1'b0}, ack);
    chk("R10 no ack on other address", {7'd0, ack}, 8'd0);
    sendByte(8'h04, ack);
    chk("R10 data not acked", {7'd0, ack}, 8'd0);
    busStop();
    waitClk(Q);
    chk("R10 selection unchanged", {6'd0, chanEnable}, 8'h02);
    readCtrl(v);
    chk("R10 control byte unchanged", v, 8'h05);
  endtask

  task automatic testMidReset();
    logic [7:0] v;
    rstN = 1'b0; waitClk(3);
    rstN = 1'b1; waitClk(3);
    chk("R8 reset clears selection", {6'd0, chanEnable}, 8'h00);
    readCtrl(v);
    chk("R8 reset clears control byte", v, 8'h00);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testSelect();
    testMultiByte();
    testReadBack();
    testMismatch();
    testMidReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule